// File: doc/BRIEF.md
# Serial Receive Register Front-End

This block is the receive side of a simple serial port, seen through a 32-bit register bus with byte addresses on word boundaries. A byte-stream source delivers received bytes with a one-cycle valid strobe. The block stores them in a 16-entry circular buffer. An enable bit in a receive-control register decides whether an arriving byte is taken or ignored.

Software reads the oldest byte through two status/data words that share one layout. The inspect word (offset 0x24) leaves the buffer unchanged. The consume word (offset 0x20) returns the same value and also removes the byte. Both words carry a data-present flag and two transmitter flags that are always set. The data-present condition is also driven onto a level output for interrupt logic.

Occupancy is tracked by a three-state machine:
- `FILL_EMPTY`: nothing stored.
- `FILL_PART`: between 1 and 15 bytes stored.
- `FILL_FULL`: 16 bytes stored.

Its transitions are:
- `FILL_EMPTY` to `FILL_PART` on an accepted byte.
- `FILL_PART` to `FILL_FULL` when a byte arrives with 15 stored and none is removed.
- `FILL_PART` to `FILL_EMPTY` when the last byte is removed with no byte arriving.
- `FILL_FULL` to `FILL_PART` on any removal.

Every other case holds the current state.

Top module: `rx_regfront`

## Requirements
- R1: After reset the buffer is empty, `rx_avail` is 0, and the words at offsets 0x00, 0x04 and 0x08 read as 0, so the receiver starts disabled.
- R2: Offsets 0x00, 0x04 and 0x08 hold all 32 written bits and read them back. A read at any other offset except 0x20 and 0x24 returns 0, and a write there changes nothing.
- R3: A byte on `rx_data` with `rx_valid` high is stored only while bit 3 of the word at 0x08 is 1. Otherwise the byte is ignored.
- R4: A read at 0x24 returns the oldest stored byte in bits 7:0 and does not change the buffer.
- R5: A read at 0x20 returns the same word as 0x24. When the buffer is not empty, it also removes the oldest byte, so bytes leave in arrival order.
- R6: Bit 16 of the status/data word and the `rx_avail` output are 1 exactly when at least one byte is stored.
- R7: Bits 22 and 24 of the status/data word always read 1. Bits 31:25, 23 and 21:17 read 0.
- R8: With 16 bytes stored, an arriving byte is discarded and the stored bytes and their order are unchanged.
- R9: A read at 0x20 on an empty buffer changes nothing. On an empty buffer, bits 7:0 return the byte held in the slot the next write will use.
- R10: A byte accepted in the same cycle as a read at 0x20 keeps the count unchanged and is queued behind the bytes already stored.
- R11: Byte order is preserved when the write position wraps from slot 15 to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; a read at 0x20 removes a byte at the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational while `reg_rd` is high, 0 otherwise |
| rx_valid | input | 1 | Received-byte strobe |
| rx_data | input | 8 | Received byte |
| rx_avail | output | 1 | High while the buffer holds a byte |

## Verification
The buffer is driven with several patterns:
- A short burst read back through both words. This separates inspecting from consuming.
- A run of sixteen distinct bytes plus one extra. This shows whether the 17th byte is dropped and whether ordering survives the index wrap.
- A consume on an empty buffer. The stale-slot value shows whether the read and write positions stayed consistent.
- A byte arriving in the same cycle as a consume. This separates a correct queue from one that loses or reorders that byte.
- A byte sent while the receiver is disabled. This shows that the enable bit really gates storage.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int REG_W      = 32;
    localparam int BYTE_W     = 8;
    localparam int NUM_CTRL   = 3;
    localparam logic [7:0] OFS_POP  = 8'h20;
    localparam logic [7:0] OFS_PEEK = 8'h24;
    localparam int BIT_AVAIL  = 16;
    localparam int BIT_TXIDLE = 22;
    localparam int BIT_TXRDY  = 24;
    localparam int RXCTRL_IDX = 2;
    localparam int RXEN_BIT   = 3;

    typedef enum logic [1:0] {
        FILL_EMPTY = 2'd0,
        FILL_PART  = 2'd1,
        FILL_FULL  = 2'd2
    } fill_t;
endpackage

// File: rtl/rxf_fifo.sv
module rxf_fifo
    import rxf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_req,
    input  logic         pop_req,
    input  logic [W-1:0] din,
    output logic [W-1:0] head,
    output logic         not_empty
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = IDX_W + 1;

    logic [W-1:0]     mem [DEPTH];
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic [CNT_W-1:0] count;
    fill_t            state, state_nx;
    logic             push_ok, pop_ok;

    assign push_ok = push_req && (state != FILL_FULL);
    assign pop_ok  = pop_req && (state != FILL_EMPTY);
    assign rd_idx  = wr_idx - count[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_idx] <= din;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            FILL_EMPTY: if (push_ok) state_nx = FILL_PART;
            FILL_PART: begin
                if (push_ok && !pop_ok && count == CNT_W'(DEPTH - 1))
                    state_nx = FILL_FULL;
                else if (pop_ok && !push_ok && count == CNT_W'(1))
                    state_nx = FILL_EMPTY;
            end
            FILL_FULL: if (pop_ok) state_nx = FILL_PART;
            default:   state_nx = FILL_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= FILL_EMPTY;
            count  <= '0;
            wr_idx <= '0;
        end else begin
            state <= state_nx;
            if (push_ok) wr_idx <= wr_idx + 1'b1;
            if (push_ok && !pop_ok)      count <= count + 1'b1;
            else if (pop_ok && !push_ok) count <= count - 1'b1;
        end
    end

    always_comb begin
        head      = mem[rd_idx];
        not_empty = (state != FILL_EMPTY);
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    // R6
    empty_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FILL_EMPTY) == (count == '0));
    // R8
    full_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FILL_FULL) == (count == CNT_W'(DEPTH)));
    // R8
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_W'(DEPTH) && push_req && !pop_req) |=> $stable(wr_idx));
    // R9
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && pop_req && !push_req) |=> (count == '0));
    // R10
    push_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && pop_req && count != '0 && count != CNT_W'(DEPTH)) |=> $stable(count));
endmodule

// File: rtl/rxf_ctrl_regs.sv
module rxf_ctrl_regs
    import rxf_pkg::*;
#(
    parameter int NREG = 3,
    parameter int W    = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NREG-1:0]        wr_sel,
    input  logic [W-1:0]           wdata,
    output logic [NREG-1:0][W-1:0] q
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         q[g] <= '0;
            else if (wr_sel[g]) q[g] <= wdata;
        end
    end

    // R2
    one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));
endmodule

// File: rtl/rxf_rdmux.sv
module rxf_rdmux
    import rxf_pkg::*;
#(
    parameter int NREG = 3,
    parameter int W    = 32
) (
    input  logic                   rd_en,
    input  logic [7:0]             addr,
    input  logic [NREG-1:0][W-1:0] ctrl_q,
    input  logic [BYTE_W-1:0]      head,
    input  logic                   not_empty,
    output logic [W-1:0]           rdata,
    output logic                   pop_req
);
    logic [W-1:0] stat_word;

    always_comb begin
        stat_word                = '0;
        stat_word[BYTE_W-1:0]    = head;
        stat_word[BIT_AVAIL]     = not_empty;
        stat_word[BIT_TXIDLE]    = 1'b1;
        stat_word[BIT_TXRDY]     = 1'b1;
    end

    always_comb begin
        rdata   = '0;
        pop_req = 1'b0;
        if (rd_en) begin
            if (addr == OFS_PEEK) begin
                rdata = stat_word;
            end else if (addr == OFS_POP) begin
                rdata   = stat_word;
                pop_req = 1'b1;
            end else begin
                for (int i = 0; i < NREG; i++)
                    if (addr == 8'(i * 4)) rdata = ctrl_q[i];
            end
        end
    end
endmodule

// File: rtl/rx_regfront.sv
module rx_regfront
    import rxf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  reg_addr,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    output logic        rx_avail
);
    logic [NUM_CTRL-1:0]            wr_sel;
    logic [NUM_CTRL-1:0][REG_W-1:0] ctrl_q;
    logic [BYTE_W-1:0]              head;
    logic                           not_empty, pop_req, push_req;

    always_comb begin
        for (int i = 0; i < NUM_CTRL; i++)
            wr_sel[i] = reg_wr && (reg_addr == 8'(i * 4));
    end

    assign push_req = rx_valid && ctrl_q[RXCTRL_IDX][RXEN_BIT];

    rxf_ctrl_regs #(.NREG(NUM_CTRL), .W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wdata(reg_wdata), .q(ctrl_q));

    rxf_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
        .din(rx_data), .head(head), .not_empty(not_empty));

    rxf_rdmux #(.NREG(NUM_CTRL), .W(REG_W)) u_mux (
        .rd_en(reg_rd), .addr(reg_addr), .ctrl_q(ctrl_q), .head(head),
        .not_empty(not_empty), .rdata(reg_rdata), .pop_req(pop_req));

    assign rx_avail = not_empty;

    // R7
    fixed_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && (reg_addr == OFS_PEEK || reg_addr == OFS_POP)) |->
            (reg_rdata[BIT_TXRDY] && reg_rdata[BIT_TXIDLE]));
    // R6
    avail_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == OFS_PEEK) |-> (reg_rdata[BIT_AVAIL] == rx_avail));
    // R3
    rx_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[RXCTRL_IDX][RXEN_BIT] && !rx_avail) |=> !rx_avail);
endmodule

// File: tb/rx_regfront_tb.sv
module rx_regfront_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NV = 21;
    localparam logic [31:0] FLAGS = 32'h0140_0000;
    localparam logic [31:0] AV    = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, rx_valid = 1'b0;
    logic [31:0] reg_wdata = '0, reg_rdata, last_rd;
    logic [7:0]  rx_data = '0;
    logic        rx_avail;
    int          n_run = 0, n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rx_regfront dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_avail(rx_avail));

    // fields: req[77:74] op[73:72] addr[71:64] data[63:32] exp[31:0]
    // op 0 write, 1 read full compare, 2 read compare bits 31:8, 3 push byte
    localparam logic [77:0] VEC [NV] = '{
        {4'd1, 2'd1, 8'h00, 32'h0, 32'h0},                  // R1
        {4'd1, 2'd1, 8'h08, 32'h0, 32'h0},                  // R1
        {4'd2, 2'd0, 8'h00, 32'hDEADBEEF, 32'h0},           // R2
        {4'd2, 2'd0, 8'h04, 32'h12345678, 32'h0},
        {4'd2, 2'd1, 8'h00, 32'h0, 32'hDEADBEEF},
        {4'd2, 2'd1, 8'h04, 32'h0, 32'h12345678},
        {4'd2, 2'd0, 8'h0C, 32'h55, 32'h0},
        {4'd2, 2'd1, 8'h0C, 32'h0, 32'h0},
        {4'd3, 2'd3, 8'h00, 32'hA5, 32'h0},                 // R3 disabled
        {4'd3, 2'd2, 8'h24, 32'h0, FLAGS},
        {4'd3, 2'd0, 8'h08, 32'h8, 32'h0},
        {4'd3, 2'd3, 8'h00, 32'h11, 32'h0},
        {4'd3, 2'd3, 8'h00, 32'h22, 32'h0},
        {4'd3, 2'd3, 8'h00, 32'h33, 32'h0},
        {4'd4, 2'd1, 8'h24, 32'h0, FLAGS | AV | 32'h11},    // R4
        {4'd4, 2'd1, 8'h24, 32'h0, FLAGS | AV | 32'h11},
        {4'd5, 2'd1, 8'h20, 32'h0, FLAGS | AV | 32'h11},    // R5
        {4'd5, 2'd1, 8'h20, 32'h0, FLAGS | AV | 32'h22},
        {4'd6, 2'd1, 8'h24, 32'h0, FLAGS | AV | 32'h33},    // R6
        {4'd5, 2'd1, 8'h20, 32'h0, FLAGS | AV | 32'h33},
        {4'd7, 2'd2, 8'h24, 32'h0, FLAGS}                   // R7
    };

    task automatic cyc(input logic wr, input logic rd, input logic [7:0] a,
                       input logic [31:0] wd, input logic vld, input logic [7:0] b);
        @(negedge clk);
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
        rx_valid = vld; rx_data = b;
        #1 last_rd = reg_rdata;
        @(posedge clk);
        #1;
        reg_wr = 1'b0; reg_rd = 1'b0; rx_valid = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk("R1 avail after reset", {31'b0, rx_avail}, 32'h0);
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d table row %0d", VEC[i][77:74], i);
            unique case (VEC[i][73:72])
                2'd0: cyc(1'b1, 1'b0, VEC[i][71:64], VEC[i][63:32], 1'b0, 8'h0);
                2'd1: begin
                    cyc(1'b0, 1'b1, VEC[i][71:64], 32'h0, 1'b0, 8'h0);
                    chk(tag, last_rd, VEC[i][31:0]);
                end
                2'd2: begin
                    cyc(1'b0, 1'b1, VEC[i][71:64], 32'h0, 1'b0, 8'h0);
                    chk(tag, last_rd & 32'hFFFF_FF00, VEC[i][31:0]);
                end
                default: cyc(1'b0, 1'b0, 8'h0, 32'h0, 1'b1, VEC[i][39:32]);
            endcase
        end
        chk("R6 avail low when drained", {31'b0, rx_avail}, 32'h0);

        // R8 / R11: fill 16 bytes from slot 3, crossing slot 15 -> 0
        for (int i = 0; i < 16; i++) cyc(1'b0, 1'b0, 8'h0, 32'h0, 1'b1, 8'(8'h40 + i));
        chk("R6 avail when full", {31'b0, rx_avail}, 32'h1);
        cyc(1'b0, 1'b0, 8'h0, 32'h0, 1'b1, 8'hEE);
        for (int i = 0; i < 16; i++) begin
            cyc(1'b0, 1'b1, 8'h20, 32'h0, 1'b0, 8'h0);
            chk($sformatf("R8 R11 drain %0d", i), last_rd, FLAGS | AV | 32'(8'h40 + i));
        end
        // R9: empty; next write slot is 3 which holds 0x40
        cyc(1'b0, 1'b1, 8'h24, 32'h0, 1'b0, 8'h0);
        chk("R9 stale slot", last_rd, FLAGS | 32'h40);
        cyc(1'b0, 1'b1, 8'h20, 32'h0, 1'b0, 8'h0);
        chk("R9 empty pop word", last_rd, FLAGS | 32'h40);
        cyc(1'b0, 1'b0, 8'h0, 32'h0, 1'b1, 8'h77);
        cyc(1'b0, 1'b1, 8'h24, 32'h0, 1'b0, 8'h0);
        chk("R9 count intact after empty pop", last_rd, FLAGS | AV | 32'h77);

        // R10: push 0x91 while popping 0x77
        cyc(1'b0, 1'b1, 8'h20, 32'h0, 1'b1, 8'h91);
        chk("R10 pop with push", last_rd, FLAGS | AV | 32'h77);
        cyc(1'b0, 1'b1, 8'h20, 32'h0, 1'b0, 8'h0);
        chk("R10 queued byte", last_rd, FLAGS | AV | 32'h91);
        chk("R10 empty after", {31'b0, rx_avail}, 32'h0);

        // R3: disable again, byte ignored
        cyc(1'b1, 1'b0, 8'h08, 32'h0, 1'b0, 8'h0);
        cyc(1'b0, 1'b0, 8'h0, 32'h0, 1'b1, 8'h5A);
        chk("R3 disabled drop", {31'b0, rx_avail}, 32'h0);

        // R1: reset with data stored
        cyc(1'b1, 1'b0, 8'h08, 32'h8, 1'b0, 8'h0);
        cyc(1'b0, 1'b0, 8'h0, 32'h0, 1'b1, 8'h3C);
        chk("R1 pre-reset avail", {31'b0, rx_avail}, 32'h1);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        chk("R1 avail cleared", {31'b0, rx_avail}, 32'h0);
        cyc(1'b0, 1'b1, 8'h08, 32'h0, 1'b0, 8'h0);
        chk("R1 rx ctrl cleared", last_rd, 32'h0);
        cyc(1'b0, 1'b1, 8'h04, 32'h0, 1'b0, 8'h0);
        chk("R1 dma reg cleared", last_rd, 32'h0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule